// File: doc/BRIEF.md
# Software Reset Line Controller

This block sits on a simple register bus and drives a bank of active-high reset outputs, one per target line, grouped 32 lines to a control word. Line N belongs to word N/32 at bit N%32. Software can control each line in two independent ways. The first is a one-shot pulse. Writing a one to the line's bit in a pulse word asserts the line for a fixed number of clock cycles, and the pulse then ends by itself. The second is a level hold. Clearing the line's bit in a level word holds the line in reset until software sets that bit again.

The pulse words occupy consecutive word addresses starting at byte 0. The level words start at a byte offset set by a parameter. Typical configurations are 8 words with the level window at 0x7C, and 3 words with the level window at 0x40. Level words read back, so software can change one bit by read-modify-write. A read of a pulse word returns which lines are currently pulsing. The bus has no handshake. A write takes effect on the clock edge where `bus_we` is sampled, and read data is a combinational function of `bus_addr`.

Top module: `rstline_ctrl`

## Requirements
- R1: After reset every `rst_o` bit is 0, every level word reads 0xFFFFFFFF and every pulse word reads 0.
- R2: Line N is controlled by bit N%32 of pulse word N/32 at byte address 4·(N/32), and by the same bit of level word N/32.
- R3: Writing a one to a pulse bit asserts that line for exactly PULSE_LEN (default 16) cycles. A pulse-word bit written as zero leaves its line unchanged.
- R4: Writing a one to a line that is already pulsing restarts its count, so the line stays high PULSE_LEN cycles after the latest write.
- R5: Level word k sits at byte address LEVEL_OFS+4·k (default 0x7C) and reads back the last value written to it.
- R6: `rst_o[N]` is 1 whenever level bit N is 0 or line N is pulsing, and 0 otherwise. A level bit of 1 releases the line.
- R7: A read of pulse word k returns 1 in each bit whose line is currently pulsing.
- R8: Unmapped addresses read as 0 and ignore writes. This covers addresses that are not word aligned, addresses beyond either window, and the gap between the two windows.
- R9: `rst_o` is registered. It changes on the same clock edge that samples the qualifying write, so it is visible one cycle after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller itself |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per sampled cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_o | output | 32·NUM_REGS (256) | Reset outputs, 1 = line held in reset |

## Verification
A write is sampled at one rising edge, and its effect on `rst_o` and on read data is due right after that edge. The bench drives inputs and samples outputs on falling edges, so it checks the result half a cycle after the capturing edge. A pulse is high at the first falling edge after the write and at the next PULSE_LEN-1 falling edges, and it is low at the falling edge that follows them. The bench counts these edges explicitly, including the case where a restart extends the pulse. Read data needs no clock, so read checks are made a moment after the address is set.

// File: rtl/rstline_pkg.sv
package rstline_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_PULSE = 2'd1,
    SEL_LEVEL = 2'd2
  } sel_kind_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rstline_decode.sv
module rstline_decode
  import rstline_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LEVEL_OFS = 'h7C,
  localparam int unsigned IDX_W    = idx_width(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [31:0] PULSE_END = 32'(4 * NUM_REGS);
  localparam logic [31:0] LVL_BASE  = 32'(LEVEL_OFS);
  localparam logic [31:0] LVL_END   = 32'(LEVEL_OFS + 4 * NUM_REGS);

  logic [31:0] a_ext;
  logic [31:0] l_rel;

  always_comb begin
    a_ext = 32'(addr);
    l_rel = a_ext - LVL_BASE;
    kind  = SEL_NONE;
    idx   = '0;
    if (a_ext[1:0] == 2'b00 && a_ext < PULSE_END) begin
      kind = SEL_PULSE;
      idx  = IDX_W'(a_ext >> 2);
    end else if (a_ext >= LVL_BASE && a_ext < LVL_END && l_rel[1:0] == 2'b00) begin
      kind = SEL_LEVEL;
      idx  = IDX_W'(l_rel >> 2);
    end
  end
endmodule

// File: rtl/rstline_pulse.sv
module rstline_pulse #(
  parameter int unsigned LINES     = 256,
  parameter int unsigned PULSE_LEN = 16,
  localparam int unsigned CNT_W    = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] start,
  output logic [LINES-1:0] active,
  output logic [LINES-1:0] active_nxt
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
      if (start[i])            cnt_d = CNT_W'(PULSE_LEN);
      else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
      else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign active[i]     = (cnt_q != '0);
    assign active_nxt[i] = (cnt_d != '0);
  end
endmodule

// File: rtl/rstline_level.sv
module rstline_level
  import rstline_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned LINES   = WORD_W * NUM_REGS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] load,
  input  logic [WORD_W-1:0]   wdata,
  output logic [LINES-1:0]    lvl_q,
  output logic [LINES-1:0]    lvl_nxt
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    assign lvl_nxt[k*WORD_W +: WORD_W] = load[k] ? wdata : lvl_q[k*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl_nxt;
  end
endmodule

// File: rtl/rstline_ctrl.sv
module rstline_ctrl
  import rstline_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LEVEL_OFS = 'h7C,
  parameter int unsigned PULSE_LEN = 16,
  localparam int unsigned LINES    = WORD_W * NUM_REGS,
  localparam int unsigned IDX_W    = idx_width(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic [LINES-1:0]  rst_o
);
  sel_kind_e            kind;
  logic [IDX_W-1:0]     idx;
  logic [NUM_REGS-1:0]  pulse_we;
  logic [NUM_REGS-1:0]  level_we;
  logic [LINES-1:0]     start;
  logic [LINES-1:0]     pulse_act;
  logic [LINES-1:0]     pulse_act_nxt;
  logic [LINES-1:0]     lvl_q;
  logic [LINES-1:0]     lvl_nxt;
  logic [LINES-1:0]     rst_q;

  rstline_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .LEVEL_OFS(LEVEL_OFS)
  ) u_dec (
    .addr(bus_addr),
    .kind(kind),
    .idx (idx)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_we
    assign pulse_we[k] = bus_we && kind == SEL_PULSE && idx == IDX_W'(k);
    assign level_we[k] = bus_we && kind == SEL_LEVEL && idx == IDX_W'(k);
    assign start[k*WORD_W +: WORD_W] = pulse_we[k] ? bus_wdata : '0;
  end

  rstline_pulse #(
    .LINES    (LINES),
    .PULSE_LEN(PULSE_LEN)
  ) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .active    (pulse_act),
    .active_nxt(pulse_act_nxt)
  );

  rstline_level #(
    .NUM_REGS(NUM_REGS)
  ) u_level (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (level_we),
    .wdata  (bus_wdata),
    .lvl_q  (lvl_q),
    .lvl_nxt(lvl_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= pulse_act_nxt | ~lvl_nxt;
  end
  assign rst_o = rst_q;

  always_comb begin
    unique case (kind)
      SEL_PULSE: bus_rdata = pulse_act[32'(idx)*WORD_W +: WORD_W];
      SEL_LEVEL: bus_rdata = lvl_q[32'(idx)*WORD_W +: WORD_W];
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rstline_ctrl_chk.sv
module rstline_ctrl_chk #(
  parameter int unsigned LINES     = 256,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LEVEL_OFS = 'h7C
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic [LINES-1:0]  rst_o,
  input logic [LINES-1:0]  lvl_q,
  input logic [LINES-1:0]  pulse_act
);
  p_level_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (~lvl_q & ~rst_o) == '0);

  p_pulse_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_act & ~rst_o) == '0);

  p_pulse_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0 && bus_wdata[0]) |=> rst_o[0]);

  p_level_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && 32'(bus_addr) == 32'(LEVEL_OFS)) |=> lvl_q[31:0] == $past(bus_wdata));

  p_odd_addr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[1:0] != 2'b00) |=> ($stable(lvl_q) && (pulse_act & ~$past(pulse_act)) == '0));
endmodule

bind rstline_ctrl rstline_ctrl_chk #(
  .LINES    (LINES),
  .ADDR_W   (ADDR_W),
  .LEVEL_OFS(LEVEL_OFS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_we   (bus_we),
  .rst_o    (rst_o),
  .lvl_q    (lvl_q),
  .pulse_act(pulse_act)
);

// File: tb/rstline_ctrl_test.sv
module rstline_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG  = 8;
  localparam int LINES = 32 * NREG;
  localparam int PLEN  = 16;
  localparam int LOFS  = 'h7C;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  // table: optional write, then read back same address and compare (R5, R8)
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'h7C, 32'hFFFF_FFFE, 32'hFFFF_FFFE},
    '{1'b1, 8'h80, 32'h0000_FFFF, 32'h0000_FFFF},
    '{1'b1, 8'h98, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    '{1'b1, 8'h7E, 32'h0000_0000, 32'h0000_0000},
    '{1'b1, 8'h9C, 32'h0000_0000, 32'h0000_0000},
    '{1'b1, 8'h40, 32'h0000_0000, 32'h0000_0000},
    '{1'b0, 8'h7C, 32'h0000_0000, 32'hFFFF_FFFE},
    '{1'b0, 8'h20, 32'h0000_0000, 32'h0000_0000},
    '{1'b1, 8'h7C, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{1'b1, 8'h98, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic             bus_we = 1'b0;
  logic [31:0]      bus_rdata;
  logic [LINES-1:0] rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstline_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .rst_o(rst_o)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [LINES-1:0] exp_o;
    int hi;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 outputs", rst_o, '0);
    rd(8'h7C, r); chk("R1 level word 0", r, 32'hFFFF_FFFF);
    rd(8'h98, r); chk("R1 level word 7", r, 32'hFFFF_FFFF);
    rd(8'h1C, r); chk("R1 pulse word 7", r, 32'h0);

    // table walk, R5 and R8
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].wr) wr(VECS[v].addr, VECS[v].data);
      rd(VECS[v].addr, r);
      chk($sformatf("R5/R8 vector %0d", v), r, VECS[v].exp);
    end
    // level word 1 still 0x0000FFFF: lines 48..63 held (R6)
    exp_o = '0;
    exp_o[63:48] = 16'hFFFF;
    chk("R6 level hold word 1", rst_o, exp_o);
    wr(8'h80, 32'hFFFF_FFFF);
    chk("R6 level release", rst_o, '0);

    // R2 R9: pulse on line 37 = word 1 bit 5
    wr(8'h04, 32'h0000_0020);
    exp_o = '0; exp_o[37] = 1'b1;
    chk("R2/R9 line 37 only, next cycle", rst_o, exp_o);
    rd(8'h04, r); chk("R7 pulse status", r, 32'h0000_0020);
    rd(8'h00, r); chk("R7 other word idle", r, 32'h0);
    // R3 length: already one high sample, count the rest
    hi = 1;
    for (int i = 0; i < PLEN + 3; i++) begin
      tick(1);
      if (rst_o[37]) hi++;
    end
    chk("R3 pulse length", 256'(hi), 256'(PLEN));
    rd(8'h04, r); chk("R7 pulse status cleared", r, 32'h0);

    // R3 zero bits have no effect
    wr(8'h00, 32'h0000_0000);
    chk("R3 zero write no pulse", rst_o, '0);

    // R4 restart: line 255 = word 7 bit 31
    wr(8'h1C, 32'h8000_0000);
    tick(9);
    wr(8'h1C, 32'h8000_0000);
    hi = 1;
    for (int i = 0; i < PLEN + 3; i++) begin
      tick(1);
      if (rst_o[255]) hi++;
    end
    chk("R4 restart length", 256'(hi), 256'(PLEN));

    // R3 zero bit during a pulse leaves the running pulse alone
    wr(8'h00, 32'h0000_0001);
    tick(3);
    wr(8'h00, 32'h0000_0000);
    exp_o = '0; exp_o[0] = 1'b1;
    chk("R3 zero write keeps running pulse", rst_o, exp_o);
    tick(PLEN);

    // R6 OR of pulse and level: level holds line 3, pulse on line 3 ends, line stays
    wr(8'h7C, 32'hFFFF_FFF7);
    wr(8'h00, 32'h0000_0008);
    tick(PLEN + 2);
    exp_o = '0; exp_o[3] = 1'b1;
    chk("R6 level outlasts pulse", rst_o, exp_o);
    wr(8'h7C, 32'hFFFF_FFFF);
    chk("R6 release after pulse", rst_o, '0);

    // R8 write into gap between windows ignored
    wr(8'h50, 32'hFFFF_FFFF);
    chk("R8 gap write no effect", rst_o, '0);
    rd(8'h50, r); chk("R8 gap read zero", r, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule